// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates one effective address by walking a multi-level radix tree held in memory. A request supplies the root table base, the number of index bits of the root table, and the total number of effective-address bits the tree covers. At each level the walker takes the next group of high-order address bits, reads one 8-byte entry over a 64-bit memory port, and acts on what it finds. A directory entry names the next table and that table's index width. A leaf entry ends the walk.

At the leaf, the block checks the requested access against the entry's permission bits and two key-0 authority masks. It then updates the reference and change bits, writing the entry back only if one of them changes. Finally it reports either the real address or a storage fault with a one-cycle completion pulse.

The block is meant to sit behind a translation cache. That cache starts a walk on a miss and installs the result.

Top module: `rtw_walker`

## Requirements
- R1: A walk starts when `start` is high while `busy` is low. Each level takes `size` index bits from the effective address directly below the bits already consumed. With `rem` bits remaining, the index is `(ea >> (rem-size)) & (2^size-1)`. The 8-byte entry is read from `base + index*8`.
- R2: An entry with bit 63 (valid) clear ends the walk with `fault` high, and no further memory access follows.
- R3: An entry with bit 63 set and bit 62 (leaf) clear is a directory. The next table base is `entry & 0x0FFF_FFFF_FFFF_FF00` and the next index width is `entry[4:0]`. Any table width below 5, the root included, faults.
- R4: If a table's width exceeds the remaining address bits, the walk faults. An `addr_bits` above 64 also faults, before any memory access.
- R5: When the fourth entry read is still a directory, the walk faults, so at most 4 entries are fetched.
- R6: On success, `real_addr` is `(entry & 0x01FF_FFFF_FFFF_F000 & ~M) | (ea & M)`, where `M = 2^rem - 1` and `rem` is the count of address bits left below the leaf's table.
- R7: The access code on `access` is 0 for read, 1 for write, 2 for execute and 3 reserved (always faults). Leaf bit 2 grants read, bit 1 grants read and write, and bit 0 grants execute. An access not granted faults.
- R8: `amr_top[1]` (mask bit 63) denies write, `amr_top[0]` (mask bit 62) denies read, and `iamr_top` (mask bit 62) denies execute, even when the leaf grants them.
- R9: A leaf with bit 3 set faults any access made with `problem` high.
- R10: After a permitted access, the leaf's bit 8 (reference) is set, and bit 7 (change) is also set for a write. The updated entry is written back to the same address only if it differs from the entry read. The write completes before `done`.
- R11: `done` is a one-cycle pulse that ends each walk, with `fault` valid alongside it. A memory request holds its address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken when idle) |
| ea | input | 64 | Effective address to translate |
| access | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| problem | input | 1 | Access made in problem (user) state |
| amr_top | input | 2 | Key-0 data mask: [1] denies write, [0] denies read |
| iamr_top | input | 1 | Key-0 instruction mask: denies execute |
| root_base | input | 64 | Root table base, 8-byte aligned |
| root_size | input | 5 | Index width of the root table |
| addr_bits | input | 7 | Total effective-address bits covered by the tree |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Entry address |
| mem_wdata | output | 64 | Entry write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 64 | Entry read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle walk completion |
| fault | output | 1 | Storage fault for the finished walk |
| real_addr | output | 64 | Translated address when no fault |

## Verification
The assertions assume that `root_base` is 8-byte aligned. They also assume that `mem_ack` is raised only while `mem_req` is high and lasts one cycle per request. The bench's memory model answers only pending requests, after a random delay of zero or more cycles, and drops `mem_ack` on the following cycle. Every root base the bench supplies is a multiple of 256. Directory bases come from masked entry fields, so every fetched address stays aligned, and randomly built trees exercise all levels.

// File: rtl/rtw_pkg.sv
package rtw_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_READ,
        ST_EVAL,
        ST_WRITE,
        ST_FINISH
    } walk_st_e;

    // entry field masks
    localparam logic [63:0] ENT_VALID   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ENT_LEAF    = 64'h4000_0000_0000_0000;
    localparam logic [63:0] ENT_NEXT    = 64'h0FFF_FFFF_FFFF_FF00;
    localparam logic [63:0] ENT_PAGE    = 64'h01FF_FFFF_FFFF_F000;
    localparam logic [63:0] ENT_REF     = 64'h0000_0000_0000_0100;
    localparam logic [63:0] ENT_CHG     = 64'h0000_0000_0000_0080;

endpackage

// File: rtl/rtw_index.sv
// Per-level index extraction and entry address generation.
module rtw_index #(
    parameter int AW    = 64,
    parameter int CW    = 7,
    parameter int SW    = 5,
    parameter int MINSZ = 5
) (
    input  logic [AW-1:0] ea,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] rem,
    input  logic [SW-1:0] size,
    output logic [AW-1:0] entry_addr,
    output logic [CW-1:0] rem_next,
    output logic          too_small,
    output logic          overrun
);
    localparam int ENT_SHIFT = 3;

    logic [CW-1:0] size_ext;
    logic [AW-1:0] idx_mask;
    logic [AW-1:0] idx;

    always_comb begin
        size_ext   = CW'(size);
        too_small  = size < SW'(MINSZ);
        overrun    = size_ext > rem;
        rem_next   = rem - size_ext;
        idx_mask   = (AW'(1) << size) - AW'(1);
        idx        = (ea >> rem_next) & idx_mask;
        entry_addr = base + (idx << ENT_SHIFT);
    end
endmodule

// File: rtl/rtw_entry_dec.sv
// Field decode of one 8-byte tree entry.
module rtw_entry_dec #(
    parameter int SW = 5
) (
    input  logic [63:0]   entry,
    output logic          valid,
    output logic          leaf,
    output logic [63:0]   next_base,
    output logic [SW-1:0] next_size,
    output logic [63:0]   page_bits,
    output logic [3:0]    perm
);
    import rtw_pkg::*;

    always_comb begin
        valid     = (entry & ENT_VALID) != 64'd0;
        leaf      = (entry & ENT_LEAF) != 64'd0;
        next_base = entry & ENT_NEXT;
        next_size = entry[SW-1:0];
        page_bits = entry & ENT_PAGE;
        perm      = entry[3:0];
    end
endmodule

// File: rtl/rtw_perm.sv
// Leaf permission and authority-mask gating.
module rtw_perm (
    input  logic [3:0]     perm,
    input  rtw_pkg::acc_e  access,
    input  logic           problem,
    input  logic [1:0]     amr_top,
    input  logic           iamr_top,
    output logic           allow
);
    import rtw_pkg::*;

    logic leaf_rd, leaf_wr, leaf_ex, priv_block;

    always_comb begin
        leaf_rd    = perm[2] | perm[1];
        leaf_wr    = perm[1];
        leaf_ex    = perm[0];
        priv_block = perm[3] & problem;
        unique case (access)
            ACC_READ:  allow = leaf_rd & ~amr_top[0];
            ACC_WRITE: allow = leaf_wr & ~amr_top[1];
            ACC_EXEC:  allow = leaf_ex & ~iamr_top;
            default:   allow = 1'b0;
        endcase
        if (priv_block) allow = 1'b0;
    end
endmodule

// File: rtl/rtw_walker.sv
module rtw_walker #(
    parameter int AW         = 64,
    parameter int SW         = 5,
    parameter int MAX_LEVELS = 4,
    parameter int MIN_SIZE   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [63:0]   ea,
    input  logic [1:0]    access,
    input  logic          problem,
    input  logic [1:0]    amr_top,
    input  logic          iamr_top,
    input  logic [63:0]   root_base,
    input  logic [4:0]    root_size,
    input  logic [6:0]    addr_bits,
    output logic          mem_req,
    output logic          mem_we,
    output logic [63:0]   mem_addr,
    output logic [63:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [63:0]   mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          fault,
    output logic [63:0]   real_addr
);
    import rtw_pkg::*;

    localparam int CW    = $clog2(AW + 1);
    localparam int LVL_W = $clog2(MAX_LEVELS + 1);

    typedef struct packed {
        walk_st_e          st;
        logic [AW-1:0]     ea;
        acc_e              acc;
        logic              prob;
        logic [1:0]        amr;
        logic              iamr;
        logic [AW-1:0]     base;
        logic [SW-1:0]     size;
        logic [CW-1:0]     rem;
        logic [LVL_W-1:0]  lvl;
        logic [AW-1:0]     addr;
        logic [63:0]       ent;
        logic [AW-1:0]     ra;
        logic              fault;
    } walk_t;

    walk_t walk_d, walk_q;

    // index datapath
    logic [AW-1:0] ix_addr;
    logic [CW-1:0] ix_rem;
    logic          ix_small, ix_over;

    rtw_index #(.AW(AW), .CW(CW), .SW(SW), .MINSZ(MIN_SIZE)) u_index (
        .ea         (walk_q.ea),
        .base       (walk_q.base),
        .rem        (walk_q.rem),
        .size       (walk_q.size),
        .entry_addr (ix_addr),
        .rem_next   (ix_rem),
        .too_small  (ix_small),
        .overrun    (ix_over)
    );

    // entry decode
    logic          e_valid, e_leaf;
    logic [63:0]   e_next, e_page;
    logic [SW-1:0] e_size;
    logic [3:0]    e_perm;

    rtw_entry_dec #(.SW(SW)) u_dec (
        .entry     (walk_q.ent),
        .valid     (e_valid),
        .leaf      (e_leaf),
        .next_base (e_next),
        .next_size (e_size),
        .page_bits (e_page),
        .perm      (e_perm)
    );

    // permission gate
    logic p_allow;

    rtw_perm u_perm (
        .perm     (e_perm),
        .access   (walk_q.acc),
        .problem  (walk_q.prob),
        .amr_top  (walk_q.amr),
        .iamr_top (walk_q.iamr),
        .allow    (p_allow)
    );

    logic [AW-1:0] off_mask;
    logic [63:0]   ent_upd;

    always_comb begin
        walk_d   = walk_q;
        off_mask = (AW'(1) << walk_q.rem) - AW'(1);
        ent_upd  = walk_q.ent | ENT_REF | ((walk_q.acc == ACC_WRITE) ? ENT_CHG : 64'd0);

        unique case (walk_q.st)
            ST_IDLE: begin
                if (start) begin
                    walk_d.ea    = ea;
                    walk_d.acc   = acc_e'(access);
                    walk_d.prob  = problem;
                    walk_d.amr   = amr_top;
                    walk_d.iamr  = iamr_top;
                    walk_d.base  = root_base;
                    walk_d.size  = root_size;
                    walk_d.rem   = CW'(addr_bits);
                    walk_d.lvl   = '0;
                    walk_d.ra    = '0;
                    walk_d.fault = 1'b0;
                    if (32'(addr_bits) > AW) begin
                        walk_d.fault = 1'b1;
                        walk_d.st    = ST_FINISH;
                    end else begin
                        walk_d.st    = ST_STEP;
                    end
                end
            end
            ST_STEP: begin
                if (ix_small || ix_over) begin
                    walk_d.fault = 1'b1;
                    walk_d.st    = ST_FINISH;
                end else begin
                    walk_d.addr = ix_addr;
                    walk_d.rem  = ix_rem;
                    walk_d.st   = ST_READ;
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    walk_d.ent = mem_rdata;
                    walk_d.lvl = walk_q.lvl + LVL_W'(1);
                    walk_d.st  = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (!e_valid) begin
                    walk_d.fault = 1'b1;
                    walk_d.st    = ST_FINISH;
                end else if (e_leaf) begin
                    if (!p_allow) begin
                        walk_d.fault = 1'b1;
                        walk_d.st    = ST_FINISH;
                    end else begin
                        walk_d.ra  = (e_page & ~off_mask) | (walk_q.ea & off_mask);
                        walk_d.ent = ent_upd;
                        walk_d.st  = (ent_upd != walk_q.ent) ? ST_WRITE : ST_FINISH;
                    end
                end else if (32'(walk_q.lvl) >= MAX_LEVELS) begin
                    walk_d.fault = 1'b1;
                    walk_d.st    = ST_FINISH;
                end else begin
                    walk_d.base = e_next;
                    walk_d.size = e_size;
                    walk_d.st   = ST_STEP;
                end
            end
            ST_WRITE: begin
                if (mem_ack) walk_d.st = ST_FINISH;
            end
            ST_FINISH: begin
                walk_d.st = ST_IDLE;
            end
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '{st: ST_IDLE, acc: ACC_READ, default: '0};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign mem_req   = (walk_q.st == ST_READ) || (walk_q.st == ST_WRITE);
    assign mem_we    = (walk_q.st == ST_WRITE);
    assign mem_addr  = walk_q.addr;
    assign mem_wdata = walk_q.ent;
    assign busy      = (walk_q.st != ST_IDLE);
    assign done      = (walk_q.st == ST_FINISH);
    assign fault     = walk_q.fault;
    assign real_addr = walk_q.ra;

endmodule

// File: rtl/rtw_walker_chk.sv
module rtw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic [63:0] mem_addr,
    input logic [63:0] mem_wdata,
    input logic        mem_ack,
    input logic        done,
    input logic        fault
);
    // R11: request held until accepted
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R11: completion is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: entry fetches are 8-byte aligned
    p_addr_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[2:0] == 3'b000);

    // R10: written-back entry always carries the reference bit
    p_wb_ref_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[8]);

    // R10: writeback finishes right before completion
    p_wb_then_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> done && !fault);

    // R2: a faulted walk issues no memory access
    p_fault_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !mem_req);
endmodule

bind rtw_walker rtw_walker_chk u_chk (.*);

// File: tb/tb_rtw_walker.sv
module tb_rtw_walker;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] ROOT = 64'h0000_0000_0000_1000;
    localparam logic [63:0] V = 64'h8000_0000_0000_0000;
    localparam logic [63:0] L = 64'h4000_0000_0000_0000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [63:0] ea = '0, root_base = '0, mem_addr, mem_wdata, mem_rdata = '0, real_addr;
    logic [1:0] access = '0, amr_top = '0;
    logic problem = 1'b0, iamr_top = 1'b0, mem_req, mem_we, mem_ack = 1'b0, busy, done, fault;
    logic [4:0] root_size = '0;
    logic [6:0] addr_bits = '0;

    int n_chk = 0, n_bad = 0, wr_cnt = 0, rd_cnt = 0;
    logic [63:0] first_addr;
    logic [63:0] mem [logic [63:0]];
    logic [63:0] path_a [5];

    bit exp_fault, exp_wb;
    logic [63:0] exp_ra, exp_ent, exp_la;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtw_walker dut (.*);

    // memory model: random latency, single-cycle ack
    always @(negedge clk) begin
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req && ($urandom_range(0, 2) != 0)) begin
            if (rd_cnt == 0 && !mem_we) first_addr = mem_addr;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
                rd_cnt++;
            end
            mem_ack = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    // independent reference walk
    task automatic ref_walk();
        int rem, size, lvl;
        logic [63:0] base, idx, a, e, m;
        bit ok;
        exp_fault = 1'b1; exp_wb = 1'b0; exp_ra = '0; exp_la = '0; exp_ent = '0;
        if (addr_bits > 64) return;
        rem = addr_bits; size = root_size; base = root_base; lvl = 0;
        forever begin
            if (size < 5 || size > rem) return;
            rem -= size;
            idx = (ea >> rem) & ((64'd1 << size) - 1);
            a = base + idx * 8;
            e = rd(a);
            lvl++;
            if (!e[63]) return;
            if (e[62]) begin
                case (access)
                    2'd0: ok = (e[2] || e[1]) && !amr_top[0];
                    2'd1: ok = e[1] && !amr_top[1];
                    2'd2: ok = e[0] && !iamr_top;
                    default: ok = 1'b0;
                endcase
                if (e[3] && problem) ok = 1'b0;
                if (!ok) return;
                m = (64'd1 << rem) - 1;
                exp_fault = 1'b0;
                exp_la = a;
                exp_ra = (e & 64'h01FF_FFFF_FFFF_F000 & ~m) | (ea & m);
                exp_ent = e | 64'h100 | (access == 2'd1 ? 64'h80 : 64'h0);
                exp_wb = (exp_ent != e);
                return;
            end
            if (lvl >= 4) return;
            base = e & 64'h0FFF_FFFF_FFFF_FF00;
            size = e[4:0];
        end
    endtask

    // builds a path for ea: nlev entries, last one = leaf
    task automatic build(input int abits, input int nlev, input int sz[5], input logic [63:0] leaf);
        int rem;
        logic [63:0] b, nb, a;
        mem.delete();
        rem = abits; b = ROOT;
        for (int k = 0; k < nlev; k++) begin
            rem -= sz[k];
            a = b + (((ea >> rem) & ((64'd1 << sz[k]) - 1)) << 3);
            path_a[k] = a;
            if (k == nlev - 1) mem[a] = leaf;
            else begin
                nb = 64'(k + 1) << 24;
                mem[a] = V | nb | 64'(sz[k+1]);
                b = nb;
            end
        end
        root_base = ROOT; root_size = 5'(sz[0]); addr_bits = 7'(abits);
    endtask

    task automatic run(input string tag);
        int w0;
        bit got;
        ref_walk();
        w0 = wr_cnt; rd_cnt = 0; first_addr = '0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        got = 1'b0;
        for (int c = 0; c < 300; c++) begin
            if (done) begin got = 1'b1; break; end
            @(negedge clk);
        end
        chk(got, {tag, " done"}, 64'(got), 64'd1);
        if (!got) return;
        chk(fault == exp_fault, {tag, " fault"}, 64'(fault), 64'(exp_fault));
        if (!exp_fault) begin
            chk(real_addr == exp_ra, {tag, " real_addr"}, real_addr, exp_ra);
            chk(rd(exp_la) == exp_ent, {tag, " entry R10"}, rd(exp_la), exp_ent);
        end
        chk((wr_cnt - w0) == int'(exp_wb), {tag, " writes R10"}, 64'(wr_cnt - w0), 64'(exp_wb));
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int sz[5];
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !mem_req && !fault, "R11 reset", {busy, done, mem_req, fault}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R6: leaf at root, hand-computed address
        sz = '{13, 0, 0, 0, 0};
        ea = 64'h0000_0080_0000_0ABC; access = 2'd0;
        build(52, 1, sz, V | L | 64'h0000_1230_0000_0000 | 64'h100 | 64'h4);
        run("R6 root leaf");
        chk(first_addr == 64'h1008, "R1 entry address", first_addr, 64'h1008);
        chk(real_addr == 64'h0000_1200_0000_0ABC, "R6 exact", real_addr, 64'h0000_1200_0000_0ABC);
        chk(wr_cnt == 0, "R10 no change no write", 64'(wr_cnt), 64'd0);

        // R10: write sets change
        access = 2'd1;
        build(52, 1, sz, V | L | 64'h0000_0400_0000_0000 | 64'h2);
        run("R10 write");
        chk(rd(path_a[0]) == (V | L | 64'h0000_0400_0000_0000 | 64'h182), "R10 R+C set",
            rd(path_a[0]), V | L | 64'h0000_0400_0000_0000 | 64'h182);

        // R2: invalid directory entry at level 2
        sz = '{9, 9, 9, 9, 0}; access = 2'd0; ea = 64'h0005_5555_5555_5555;
        build(52, 4, sz, V | L | 64'h4);
        mem[path_a[1]] = mem[path_a[1]] & ~V;
        run("R2 invalid");
        chk(fault == 1'b1, "R2 fault", 64'(fault), 64'd1);

        // R3: directory size below 5
        build(52, 4, sz, V | L | 64'h4);
        mem[path_a[0]] = (mem[path_a[0]] & ~64'h1F) | 64'h4;
        run("R3 small size");
        chk(fault == 1'b1, "R3 fault", 64'(fault), 64'd1);

        // R4: size overrun and oversize address
        sz = '{20, 0, 0, 0, 0};
        build(16, 1, sz, V | L | 64'h4);
        run("R4 overrun");
        chk(fault == 1'b1 && rd_cnt == 0, "R4 no fetch", 64'(rd_cnt), 64'd0);
        sz = '{13, 0, 0, 0, 0};
        build(52, 1, sz, V | L | 64'h4);
        addr_bits = 7'd70;
        run("R4 wide");
        chk(fault == 1'b1, "R4 wide fault", 64'(fault), 64'd1);

        // R5: five levels
        sz = '{5, 5, 5, 5, 5};
        build(52, 5, sz, V | L | 64'h4);
        run("R5 depth");
        chk(fault == 1'b1 && rd_cnt == 4, "R5 four reads", 64'(rd_cnt), 64'd4);

        // R7: read-only page written, reserved code
        sz = '{9, 9, 0, 0, 0}; access = 2'd1;
        build(52, 2, sz, V | L | 64'h4);
        run("R7 ro write");
        chk(fault == 1'b1, "R7 fault", 64'(fault), 64'd1);
        access = 2'd3;
        build(52, 2, sz, V | L | 64'h7);
        run("R7 reserved");

        // R8: masks
        access = 2'd1; amr_top = 2'b10;
        build(52, 2, sz, V | L | 64'h2);
        run("R8 amr write");
        access = 2'd2; amr_top = 2'b00; iamr_top = 1'b1;
        build(52, 2, sz, V | L | 64'h1);
        run("R8 iamr exec");
        chk(fault == 1'b1, "R8 fault", 64'(fault), 64'd1);
        iamr_top = 1'b0;

        // R9: privileged page
        access = 2'd0; problem = 1'b1;
        build(52, 2, sz, V | L | 64'hC);
        run("R9 priv");
        chk(fault == 1'b1, "R9 fault", 64'(fault), 64'd1);
        problem = 1'b0;

        // random trees
        for (int t = 0; t < 300; t++) begin
            int nl, left;
            logic [63:0] lf;
            nl = $urandom_range(1, 4);
            left = 40;
            for (int k = 0; k < 5; k++) begin
                sz[k] = (k < nl) ? $urandom_range(5, 10) : 0;
            end
            ea = {$urandom, $urandom};
            access = 2'($urandom); problem = 1'($urandom);
            amr_top = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
            iamr_top = ($urandom_range(0, 3) == 0);
            lf = V | L | ({$urandom, $urandom} & 64'h01FF_FFFF_FFFF_F000) | 64'($urandom_range(0, 15))
                 | ($urandom_range(0, 1) ? 64'h100 : 64'h0) | ($urandom_range(0, 1) ? 64'h80 : 64'h0);
            build(52, nl, sz, lf);
            if ($urandom_range(0, 9) == 0) mem[path_a[$urandom_range(0, nl-1)]] &= ~V;
            if (left < 0) left = 0;
            run("R6/R7/R10 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule